// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block turns a fast reference clock into the timing strobes a serial receiver and transmitter need. It produces a single-cycle oversample strobe at sixteen times the bit rate, and a second strobe on every sixteenth oversample strobe that marks bit boundaries. The spacing of the strobes is set by a fixed-point divisor. The divisor has an integer part of up to 16 bits and a fraction counted in sixty-fourths of a reference cycle.

A fractional accumulator adds the fraction on every strobe. Whenever that sum wraps past 64, the next strobe interval gets one extra reference cycle. The long-run average interval therefore equals the programmed divisor exactly, even though each single interval is a whole number of cycles. To hit a rate B from a reference clock F, software programs the combined divisor integer*64 + fraction to 4*F/B.

Software reaches the two divisor registers through a small write port and a combinational read port. It must program them while the generator is disabled. The read port returns exactly the stored bits, so that software can later recover the reference frequency from the divisor and a known rate.

Top module: `frac_baud_gen`

## Requirements
- R1: Register select value 0 addresses the integer divisor. A write keeps only bits 15:0 of the write data, and a read returns those 16 bits zero-extended.
- R2: Register select value 1 addresses the fraction divisor. A write keeps only bits 5:0, and a read returns those 6 bits zero-extended.
- R3: A write presented while `en` is high changes neither divisor register.
- R4: While `en` is low, or while the integer divisor is zero, `osr_tick` and `bit_tick` stay low.
- R5: After `en` goes high with a non-zero integer divisor N, the first `osr_tick` is high in the cycle following the N-th rising edge at which `en` is sampled high.
- R6: The accumulator starts at zero on enable and adds the fraction F once per `osr_tick`. Interval k (k ≥ 1, measured between `osr_tick` k-1 and k) lasts N + floor(k·F/64) − floor((k−1)·F/64) cycles.
- R7: Any 64 consecutive intervals that begin at the first strobe after enable last exactly 64·N + F cycles in total.
- R8: `bit_tick` is high together with the 16th, 32nd, 48th, … `osr_tick` after enable, and at no other time.
- R9: After reset both divisor registers read zero and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Generator enable; also locks the divisor registers |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 integer, 1 fraction |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read target: 0 integer, 1 fraction |
| rd_data | output | 32 | Selected register, zero-extended |
| osr_tick | output | 1 | Oversample strobe, sixteen per bit |
| bit_tick | output | 1 | Bit strobe, every sixteenth oversample strobe |

## Verification
A register write takes effect at the rising edge that samples it, and the read port is combinational, so the bench reads back one time step after changing `rd_sel` at the falling edge. The strobes are registered. The first one is due at the falling edge after the N-th enabled rising edge. Every later one is due a number of cycles that the bench computes from the floor formula of R6 rather than from any model of the counter. The bench numbers each falling edge from the enable, records the index of every strobe, and compares individual intervals, the first latency and the 64-interval sum against those computed values.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;

    // Widths of the fixed-point divisor and the register port
    parameter int INT_W  = 16;
    parameter int FRAC_W = 6;
    parameter int BUS_W  = 32;
    parameter int OSR    = 16;

    localparam int CNT_W = INT_W + 1;
    localparam int SUB_W = $clog2(OSR);

    // Register select encoding
    typedef enum logic {
        SEL_INT  = 1'b0,
        SEL_FRAC = 1'b1
    } reg_sel_e;

    // Fixed-point divisor: integer cycles plus fraction in 1/2^FRAC_W units
    typedef struct packed {
        logic [INT_W-1:0]  ip;
        logic [FRAC_W-1:0] fp;
    } divisor_t;

    // Timing state carried between strobes
    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [FRAC_W-1:0] acc;
        logic              stretch;
        logic              tick;
    } tick_state_t;

    localparam tick_state_t TICK_IDLE = '{cnt: '0, acc: '0, stretch: 1'b0, tick: 1'b0};

    // Accumulate the fraction; the top bit of the result is the wrap carry
    function automatic logic [FRAC_W:0] frac_add(input logic [FRAC_W-1:0] a,
                                                 input logic [FRAC_W-1:0] b);
        return {1'b0, a} + {1'b0, b};
    endfunction

    // Length of the current interval in reference cycles
    function automatic logic [CNT_W-1:0] interval_len(input logic [INT_W-1:0] ip,
                                                      input logic stretch);
        return {1'b0, ip} + {{INT_W{1'b0}}, stretch};
    endfunction

endpackage

// File: rtl/frac_baud_regs.sv
module frac_baud_regs
    import frac_baud_pkg::*;
#(
    parameter int DW = BUS_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          wr_en,
    input  logic          wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_sel,
    output logic [DW-1:0] rd_data,
    output divisor_t      div
);

    divisor_t div_q;
    logic     wr_ok;

    // Writes are accepted only while the generator is stopped
    assign wr_ok = wr_en & ~en;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
        end else if (wr_ok) begin
            if (reg_sel_e'(wr_sel) == SEL_INT)
                div_q.ip <= wr_data[INT_W-1:0];
            else
                div_q.fp <= wr_data[FRAC_W-1:0];
        end
    end

    always_comb begin
        rd_data = '0;
        if (reg_sel_e'(rd_sel) == SEL_INT)
            rd_data[INT_W-1:0] = div_q.ip;
        else
            rd_data[FRAC_W-1:0] = div_q.fp;
    end

    assign div = div_q;

endmodule

// File: rtl/frac_baud_tick.sv
module frac_baud_tick
    import frac_baud_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     run,
    input  divisor_t div,
    output logic     tick
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    tick_state_t       st_q;
    tick_state_t       st_d;
    logic [CNT_W-1:0]  limit;
    logic              last;
    logic [FRAC_W:0]   sum;

    assign limit = interval_len(div.ip, st_q.stretch);
    assign last  = (st_q.cnt == limit - ONE);
    assign sum   = frac_add(st_q.acc, div.fp);

    always_comb begin
        st_d = st_q;
        if (last) begin
            st_d.cnt     = '0;
            st_d.tick    = 1'b1;
            st_d.acc     = sum[FRAC_W-1:0];
            st_d.stretch = sum[FRAC_W];
        end else begin
            st_d.cnt  = st_q.cnt + ONE;
            st_d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !run)
            st_q <= TICK_IDLE;
        else
            st_q <= st_d;
    end

    assign tick = st_q.tick;

endmodule

// File: rtl/frac_baud_bitdiv.sv
module frac_baud_bitdiv
    import frac_baud_pkg::*;
#(
    parameter int RATIO = OSR
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    output logic bit_tick
);

    localparam int SW = (RATIO > 1) ? $clog2(RATIO) : 1;
    localparam logic [SW-1:0] TOP = SW'(RATIO - 1);
    localparam logic [SW-1:0] ONE = SW'(1);

    logic [SW-1:0] sub_q;

    always_ff @(posedge clk) begin
        if (rst || !run)
            sub_q <= '0;
        else if (tick)
            sub_q <= (sub_q == TOP) ? '0 : sub_q + ONE;
    end

    assign bit_tick = tick & (sub_q == TOP);

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
    import frac_baud_pkg::*;
#(
    parameter int DW = BUS_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          wr_en,
    input  logic          wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_sel,
    output logic [DW-1:0] rd_data,
    output logic          osr_tick,
    output logic          bit_tick
);

    divisor_t          div_q;
    logic              run;
    logic [INT_W-1:0]  div_int;
    logic [FRAC_W-1:0] div_frac;

    assign div_int  = div_q.ip;
    assign div_frac = div_q.fp;
    assign run      = en & (div_int != '0);

    frac_baud_regs #(.DW(DW)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .rd_sel  (rd_sel),
        .rd_data (rd_data),
        .div     (div_q)
    );

    frac_baud_tick u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .div  (div_q),
        .tick (osr_tick)
    );

    frac_baud_bitdiv #(.RATIO(OSR)) u_bitdiv (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .tick     (osr_tick),
        .bit_tick (bit_tick)
    );

endmodule

// File: rtl/frac_baud_chk.sv
module frac_baud_chk
    import frac_baud_pkg::*;
#(
    parameter int DW = BUS_W
) (
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic              wr_en,
    input logic              wr_sel,
    input logic [DW-1:0]     wr_data,
    input logic              osr_tick,
    input logic              bit_tick,
    input logic [INT_W-1:0]  div_int,
    input logic [FRAC_W-1:0] div_frac
);

    // R1: an accepted integer write stores the low bits of the data
    a_r1_int_store: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !en && !wr_sel) |=> (div_int == $past(wr_data[INT_W-1:0])));

    // R2: an accepted fraction write stores the low bits of the data
    a_r2_frac_store: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !en && wr_sel) |=> (div_frac == $past(wr_data[FRAC_W-1:0])));

    // R3: registers frozen while enabled
    a_r3_locked: assert property (@(posedge clk) disable iff (rst)
        en |=> ($stable(div_int) && $stable(div_frac)));

    // R4: no strobe after a disabled or zero-divisor cycle
    a_r4_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (!en || div_int == '0) |=> (!osr_tick && !bit_tick));

    // R8: bit strobe only together with an oversample strobe
    a_r8_bit_on_tick: assert property (@(posedge clk) disable iff (rst)
        bit_tick |-> osr_tick);

    // R9: reset clears outputs and registers
    a_r9_reset_state: assert property (@(posedge clk)
        rst |=> (!osr_tick && !bit_tick && div_int == '0 && div_frac == '0));

endmodule

bind frac_baud_gen frac_baud_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .osr_tick (osr_tick),
    .bit_tick (bit_tick),
    .div_int  (div_int),
    .div_frac (div_frac)
);

// File: tb/frac_baud_gen_bench.sv
module frac_baud_gen_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        en;
    logic        wr_en;
    logic        wr_sel;
    logic [31:0] wr_data;
    logic        rd_sel;
    logic [31:0] rd_data;
    logic        osr_tick;
    logic        bit_tick;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    frac_baud_gen u_frac_baud_gen (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .rd_sel   (rd_sel),
        .rd_data  (rd_data),
        .osr_tick (osr_tick),
        .bit_tick (bit_tick)
    );

    task automatic check(input string req, input longint act, input longint exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected interval k length from the floor formula
    function automatic int exp_interval(input int n, input int f, input int k);
        return n + (k * f) / 64 - ((k - 1) * f) / 64;
    endfunction

    task automatic write_reg(input bit sel, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_reg(input bit sel, output logic [31:0] data);
        @(negedge clk);
        rd_sel = sel;
        #1;
        data = rd_data;
    endtask

    // Program N and F, enable, record 65 strobes and check their timing
    task automatic run_case(input int n, input int f, input bit poke);
        int times[65];
        int cnt = 0;
        int c = 0;
        logic [31:0] rb;
        @(negedge clk);
        en = 1'b0;
        write_reg(1'b0, 32'(n));
        write_reg(1'b1, 32'(f));
        @(negedge clk);
        en = 1'b1;
        while (cnt < 65 && c < 70 * (n + 1)) begin
            if (poke && c == 2) begin
                wr_en = 1'b1; wr_sel = c[0]; wr_data = 32'hFFFF_FFFF;
            end else if (poke && c == 3) begin
                wr_en = 1'b1; wr_sel = 1'b1; wr_data = 32'h0000_0001;
            end else begin
                wr_en = 1'b0;
            end
            @(negedge clk);
            c++;
            if (osr_tick) begin
                times[cnt] = c;
                check("R8 bit strobe on 16th tick", 32'(bit_tick), 32'(((cnt % 16) == 15) ? 1 : 0));
                cnt++;
            end else if (bit_tick) begin
                check("R8 bit strobe without tick", 1, 0);
            end
        end
        wr_en = 1'b0;
        check("R6 strobe count", cnt, 65);
        if (cnt == 65) begin
            check("R5 first strobe latency", times[0], n);
            for (int k = 1; k < 65; k++)
                check("R6 interval length", times[k] - times[k-1], exp_interval(n, f, k));
            check("R7 64-interval sum", times[64] - times[0], 64 * n + f);
        end
        if (poke) begin
            en = 1'b0;
            read_reg(1'b0, rb);
            check("R3 integer unchanged", rb, n);
            read_reg(1'b1, rb);
            check("R3 fraction unchanged", rb, f);
        end
        @(negedge clk);
        en = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rb;
        int quiet;
        void'($urandom(32'h5EED_0042));
        rst = 1'b1; en = 1'b0; wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0; rd_sel = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9 reset state
        check("R9 tick low", osr_tick, 0);
        check("R9 bit low", bit_tick, 0);
        read_reg(1'b0, rb); check("R9 integer zero", rb, 0);
        read_reg(1'b1, rb); check("R9 fraction zero", rb, 0);

        // R1 / R2 width masking on readback
        write_reg(1'b0, 32'hABCD_1234);
        read_reg(1'b0, rb); check("R1 integer readback", rb, 32'h0000_1234);
        write_reg(1'b1, 32'hFFFF_FFD5);
        read_reg(1'b1, rb); check("R2 fraction readback", rb, 32'h0000_0015);
        read_reg(1'b0, rb); check("R1 integer kept", rb, 32'h0000_1234);

        // R4 integer zero with enable high: no strobes
        write_reg(1'b0, 32'h0);
        write_reg(1'b1, 32'd17);
        @(negedge clk); en = 1'b1;
        quiet = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (osr_tick || bit_tick) quiet++;
        end
        check("R4 zero divisor quiet", quiet, 0);
        en = 1'b0;

        // R4 disabled with a valid divisor: no strobes
        write_reg(1'b0, 32'd3);
        quiet = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (osr_tick || bit_tick) quiet++;
        end
        check("R4 disabled quiet", quiet, 0);

        // Directed corners
        run_case(1, 0, 1'b0);
        run_case(1, 63, 1'b0);
        run_case(2, 32, 1'b0);
        run_case(7, 1, 1'b1);
        run_case(3, 63, 1'b0);

        // Random divisors
        for (int i = 0; i < 14; i++)
            run_case(int'($urandom_range(1, 40)), int'($urandom_range(0, 63)), i[1:0] == 2'd3);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule